// File: doc/BRIEF.md
# Real-Time Clock Interrupt Source and Status Logic

This block raises the interrupt request of a real-time clock. It has three interrupt sources. A periodic source divides a fast base tick down to a programmable rate. An alarm source compares the running time against three alarm bytes whenever the clock finishes a one-second update. An update source fires on every such update. Each source latches a flag in a status byte. The request output stays asserted while any latched flag is set.

The block holds a rate/time-base byte and an enable byte. A neighbouring register bus writes both through dedicated strobes. The bus reads the flag byte through an acknowledge strobe, and that read clears the flags. The calendar counters sit outside this block and supply the current seconds, minutes and hours, together with a pulse that marks each completed one-second update. The base tick enable is expected at 65536 Hz, so a rate value `r` gives a periodic interrupt at 65536/2^r Hz.

Top module: `rtc_irq_gen`

## Requirements
- R1: After reset the rate byte reads 0x26, the enable byte reads 0x02, the flag byte reads 0x00, the validity byte reads 0x80, and `irq` is low.
- R2: With rate value r (bits 3:0 of the rate byte) in 1..15 and the periodic enable (enable byte bit 6) set, the periodic flag (flag byte bit 6) sets on the 2^r-th `tick_en` pulse counted from the last write to the rate byte, and not before.
- R3: With rate value 0, no number of `tick_en` pulses sets the periodic flag.
- R4: The alarm flag (flag byte bit 5) sets on an `upd_pulse` only when the alarm enable (enable byte bit 5) is set and seconds, minutes and hours all equal their alarm bytes. A mismatch in any one of the three fields leaves the flag clear.
- R5: The update flag (flag byte bit 4) sets on each `upd_pulse` while the update enable (enable byte bit 4) is set.
- R6: A source event that occurs while its enable bit is clear leaves its flag clear.
- R7: Bits 3:0 of the flag byte read zero. Bit 7 equals the OR of bits 6:4, and `irq` equals bit 7.
- R8: A cycle with `c_rd` high clears all flags from the next cycle on. An event that lands in that same cycle keeps its flag set.
- R9: Bit 7 of the rate byte (update in progress) always reads 0. Bits 6:0 hold the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base tick enable (65536 Hz nominal) |
| upd_pulse | input | 1 | One-cycle pulse after each one-second time update |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hours |
| a_wr | input | 1 | Write strobe for the rate byte |
| b_wr | input | 1 | Write strobe for the enable byte |
| wdata | input | 8 | Write data |
| c_rd | input | 1 | Flag byte read acknowledge (clears flags) |
| reg_a | output | 8 | Rate / time-base byte |
| reg_b | output | 8 | Enable byte |
| reg_c | output | 8 | Flag byte |
| reg_d | output | 8 | Validity byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit divider, which covers the longest period of 2^15 ticks. The periodic tests use rate values 1, 2 and 3, so the exact firing tick can be counted within a few cycles. The bench also checks the tick just before each boundary and shows that a rate write restarts the count. Rate 0 is exercised with a long run of ticks, and the alarm comparator is driven with a single-field mismatch in each position.

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
  parameter int DIV_W  = 16,
  parameter int RATE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       upd_pulse,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       a_wr,
  input  logic       b_wr,
  input  logic [7:0] wdata,
  input  logic       c_rd,
  output logic [7:0] reg_a,
  output logic [7:0] reg_b,
  output logic [7:0] reg_c,
  output logic [7:0] reg_d,
  output logic       irq
);
  localparam logic [7:0] A_RST = 8'h26;
  localparam logic [7:0] B_RST = 8'h02;

  logic [6:0]       a_q;
  logic [7:0]       b_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic             flag_p, flag_a, flag_u;
  logic             per_hit, alm_hit;
  logic             set_p, set_a, set_u;

  wire [RATE_W-1:0] rate = a_q[RATE_W-1:0];

  assign limit   = ({{(DIV_W-1){1'b0}}, 1'b1} << rate) - 1'b1;
  assign per_hit = tick_en && (rate != '0) && (div_q == limit);
  assign alm_hit = (cur_sec == alm_sec) && (cur_min == alm_min) && (cur_hour == alm_hour);

  assign set_p = per_hit && b_q[6];
  assign set_a = upd_pulse && alm_hit && b_q[5];
  assign set_u = upd_pulse && b_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_RST[6:0];
      b_q <= B_RST;
    end else begin
      if (a_wr) a_q <= wdata[6:0];
      if (b_wr) b_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  div_q <= '0;
    else if (a_wr)               div_q <= '0;
    else if (tick_en && rate != '0) div_q <= per_hit ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_p <= 1'b0;
      flag_a <= 1'b0;
      flag_u <= 1'b0;
    end else begin
      flag_p <= set_p || (flag_p && !c_rd);
      flag_a <= set_a || (flag_a && !c_rd);
      flag_u <= set_u || (flag_u && !c_rd);
    end
  end

  assign irq   = flag_p | flag_a | flag_u;
  assign reg_a = {1'b0, a_q};
  assign reg_b = b_q;
  assign reg_c = {irq, flag_p, flag_a, flag_u, 4'b0000};
  assign reg_d = 8'h80;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !upd_pulse && !tick_en) |=> !irq); // R8
  AST_NO_PER_AT_RATE0: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0 && !a_wr) |=> !$rose(flag_p)); // R3
  AST_PER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_p) |-> $past(b_q[6] && tick_en)); // R6
  AST_ALM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(upd_pulse && b_q[5] && cur_sec == alm_sec
                            && cur_min == alm_min && cur_hour == alm_hour)); // R4
  AST_UPD_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_u) |-> $past(upd_pulse && b_q[4])); // R5
  AST_UIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_a[7]); // R9
endmodule

// File: tb/rtc_irq_gen_test.sv
module rtc_irq_gen_test;
  localparam time CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic tick_en = 0, upd_pulse = 0, a_wr = 0, b_wr = 0, c_rd = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0, wdata = 0;
  logic [7:0] reg_a, reg_b, reg_c, reg_d;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_irq_gen uut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic wr_a(logic [7:0] v); wdata = v; a_wr = 1; cyc(); a_wr = 0; endtask
  task automatic wr_b(logic [7:0] v); wdata = v; b_wr = 1; cyc(); b_wr = 0; endtask
  task automatic rd_c(); c_rd = 1; cyc(); c_rd = 0; endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) begin tick_en = 1; cyc(); tick_en = 0; end endtask
  task automatic upd(); upd_pulse = 1; cyc(); upd_pulse = 0; endtask

  task automatic t_reset();
    chk("R1 reg_a", reg_a, 8'h26);
    chk("R1 reg_b", reg_b, 8'h02);
    chk("R1 reg_c", reg_c, 8'h00);
    chk("R1 reg_d", reg_d, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_periodic();
    wr_b(8'h40);
    wr_a(8'h22);
    ticks(3);
    chk("R2 rate2 before 4th tick", reg_c, 8'h00);
    ticks(1);
    chk("R2 rate2 at 4th tick", reg_c, 8'hC0);
    chk("R7 irq with periodic", {7'b0, irq}, 8'h01);
    rd_c();
    chk("R8 read clears", reg_c, 8'h00);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
    ticks(2);
    wr_a(8'h23);
    ticks(7);
    chk("R2 rate3 restart 7 ticks", reg_c, 8'h00);
    ticks(1);
    chk("R2 rate3 8th tick", reg_c, 8'hC0);
    rd_c();
    wr_a(8'h21);
    ticks(1);
    chk("R2 rate1 1st tick", reg_c, 8'h00);
    ticks(1);
    chk("R2 rate1 2nd tick", reg_c, 8'hC0);
    rd_c();
  endtask

  task automatic t_rate0();
    wr_a(8'h20);
    ticks(300);
    chk("R3 rate0 no flag", reg_c, 8'h00);
  endtask

  task automatic t_disabled();
    wr_b(8'h00);
    wr_a(8'h21);
    ticks(6);
    upd();
    chk("R6 all disabled", reg_c, 8'h00);
    chk("R6 irq low", {7'b0, irq}, 8'h00);
    wr_a(8'h20);
  endtask

  task automatic t_alarm();
    cur_sec = 8'h15; cur_min = 8'h42; cur_hour = 8'h07;
    alm_sec = 8'h15; alm_min = 8'h42; alm_hour = 8'h07;
    wr_b(8'h20);
    upd();
    chk("R4 alarm match", reg_c, 8'hA0);
    rd_c();
    alm_sec = 8'h16; upd();
    chk("R4 sec mismatch", reg_c, 8'h00);
    alm_sec = 8'h15; alm_min = 8'h43; upd();
    chk("R4 min mismatch", reg_c, 8'h00);
    alm_min = 8'h42; alm_hour = 8'h08; upd();
    chk("R4 hour mismatch", reg_c, 8'h00);
    alm_hour = 8'h07;
    chk("R4 no pulse no flag", reg_c, 8'h00);
  endtask

  task automatic t_update();
    wr_b(8'h10);
    upd();
    chk("R5 update flag", reg_c, 8'h90);
    chk("R7 low nibble zero", reg_c & 8'h0F, 8'h00);
    c_rd = 1; upd_pulse = 1; cyc(); c_rd = 0; upd_pulse = 0;
    chk("R8 same-cycle event kept", reg_c, 8'h90);
    rd_c();
    chk("R8 second read clears", reg_c, 8'h00);
  endtask

  task automatic t_rate_reg();
    wr_a(8'hFF);
    chk("R9 uip reads 0", reg_a, 8'h7F);
    wr_a(8'h26);
    chk("R9 writable bits", reg_a, 8'h26);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    cyc();
    t_reset();
    t_periodic();
    t_rate0();
    t_disabled();
    t_alarm();
    t_update();
    t_rate_reg();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule